// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block passes data between two buses, called side A and side B, without inverting it. Each direction has its own storage stage. The A-to-B stage feeds side B and the B-to-A stage feeds side A. A stage works in one of three ways:

- **Open:** its output follows its input in the same cycle.
- **Frozen:** it keeps the value it last held.
- **Capture:** it takes in new data when its capture strobe rises.

A latch-open input selects between open and the two storage modes.

The whole block runs on one system clock. The two capture strobes are ordinary inputs that the block samples on that clock. A rising edge of a strobe is the first clock cycle in which the strobe is seen high after being seen low.

For each bus the block gives a data vector and a drive-enable signal. A pad ring or bus wrapper can turn these into real three-state drivers, so the block itself contains no internal three-state nets. The two directions use enables of opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low. This lets a single shared control line point the transceiver one way or the other.

Top module: `dual_path_xcvr`

## Requirements
- R1: Every one of the XW (default 18) bits moves across unchanged and in place: bit n of an input shows up as bit n of the opposite output.
- R2: While `ab_open` is 1, `b_data` equals `a_in` in the same cycle, with no clock edge in between.
- R3: When `ab_open` goes from 1 to 0, `b_data` keeps the value `a_in` had in the last cycle that `ab_open` was 1, even if `a_in` changes in the same cycle.
- R4: While `ab_open` is 0 and `ab_strobe` has no rising edge, the stored A-to-B value does not change, whatever `a_in` does. This includes the case where the strobe is held steadily high or low.
- R5: While `ab_open` is 0, a cycle in which `ab_strobe` is 1 after a cycle in which it was 0 loads `a_in` at that clock edge, and `b_data` shows it from the next cycle on. A falling strobe loads nothing.
- R6: `ab_en` is active high. When it is 0, `b_drive` is 0 and `b_data` is all zeros, and the A-to-B stage keeps storing and capturing. When `ab_en` returns to 1, `b_data` shows whatever the stage has stored.
- R7: The B-to-A path follows R2–R5 with `ba_open`, `ba_strobe`, `b_in` and `a_data`. Its enable `ba_en_n` is active low: at 1, `a_drive` is 0 and `a_data` is all zeros.
- R8: No control, strobe or data input of one direction changes the output or the stored value of the other direction.
- R9: A synchronous active-low reset clears both stored values to zero. After release, a strobe that was already high during reset does not count as a rising edge.
- R10: With both enables active at once, each bus carries its own direction's value, in both open and capture modes, with no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | XW | Data received from side A |
| b_in | input | XW | Data received from side B |
| ab_open | input | 1 | A-to-B stage open (1) or storing (0) |
| ba_open | input | 1 | B-to-A stage open (1) or storing (0) |
| ab_strobe | input | 1 | A-to-B capture strobe; a rising edge loads the stage |
| ba_strobe | input | 1 | B-to-A capture strobe; a rising edge loads the stage |
| ab_en | input | 1 | Side-B drive enable, active high |
| ba_en_n | input | 1 | Side-A drive enable, active low |
| b_data | output | XW | Data to drive onto side B |
| b_drive | output | 1 | Side-B driver enable |
| a_data | output | XW | Data to drive onto side A |
| a_drive | output | 1 | Side-A driver enable |

## Verification
The bench builds the block with its default width of 18 bits. Its patterns set the top bit, the bottom bit and alternating bits, so a lane swap, a dropped bit or a missing top bit shows up in the checks. The one width also covers both polarities of the enable gating and the behaviour of the edge history around reset. With two directions fixed by the design, the bench can drive both stages at once and check that their values never cross.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared direction encoding for the dual-path transceiver.
// Assumes exactly two directions; the index selects the enable polarity.
package xcvr_pkg;

    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } xcvr_dir_e;

    localparam int NUM_DIRS = 2;

    // Enable polarity per direction: the B-to-A side is active low.
    function automatic bit dir_enable_low(input int dir);
        return (dir == int'(DIR_BA));
    endfunction

endpackage

// File: rtl/xcvr_rise_detect.sv
`timescale 1ns/1ps
// Module: xcvr_rise_detect
// Turns a level sampled on clk into a one-cycle rising-edge flag.
// Assumes the level is already synchronous to clk. RST_LEVEL sets the
// remembered level after reset; 1 means a level held high through
// reset is not taken as an edge.
module xcvr_rise_detect #(
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    // Remember the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= RST_LEVEL;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/xcvr_path_store.sv
`timescale 1ns/1ps
// Module: xcvr_path_store
// One storage stage that is either an open latch or an edge-loaded register.
// While open, the output is the live input and the register follows it,
// so closing the latch leaves the last open value behind. While closed,
// the register loads only on a rising strobe edge.
// Assumes the strobe is sampled on clk.
module xcvr_path_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic         strobe_rise;
    logic         load;
    logic [W-1:0] held;

    xcvr_rise_detect #(
        .RST_LEVEL (1'b1)
    ) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (strobe),
        .rise  (strobe_rise)
    );

    // Load while open (tracking) or on a strobe edge while closed.
    assign load = open_i | strobe_rise;

    // Hold register: cleared by reset, loaded on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load) begin
            held <= din;
        end
    end

    // Open stage passes the live input; closed stage shows the register.
    always_comb begin
        if (open_i) begin
            dout = din;
        end else begin
            dout = held;
        end
    end

endmodule

// File: rtl/xcvr_drive_gate.sv
`timescale 1ns/1ps
// Module: xcvr_drive_gate
// Gates stored data onto a bus driver with a selectable enable polarity.
// Assumes the downstream pad uses drive as its output enable; data is
// forced to zero while not driving, so no stale value leaks out.
module xcvr_drive_gate #(
    parameter int W          = 18,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         en_pin,
    input  logic [W-1:0] din,
    output logic         drive,
    output logic [W-1:0] dout
);

    // Pick the enable polarity at elaboration.
    generate
        if (ACTIVE_LOW) begin : g_low
            assign drive = ~en_pin;
        end else begin : g_high
            assign drive = en_pin;
        end
    endgenerate

    // Zero the data vector whenever the driver is off.
    assign dout = drive ? din : '0;

endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
// Module: dual_path_xcvr
// Two independent, non-inverting storage paths between side A and side B,
// each with its own open, strobe and enable controls. The A-to-B enable is
// active high and the B-to-A enable is active low. Outputs are split into a
// data vector and a drive enable per bus, so there are no internal
// three-state nets. Assumes all controls are synchronous to clk.
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int XW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] a_in,
    input  logic [XW-1:0] b_in,
    input  logic          ab_open,
    input  logic          ba_open,
    input  logic          ab_strobe,
    input  logic          ba_strobe,
    input  logic          ab_en,
    input  logic          ba_en_n,
    output logic [XW-1:0] b_data,
    output logic          b_drive,
    output logic [XW-1:0] a_data,
    output logic          a_drive
);

    logic [XW-1:0] src    [NUM_DIRS];
    logic          opn    [NUM_DIRS];
    logic          stb    [NUM_DIRS];
    logic          enp    [NUM_DIRS];
    logic [XW-1:0] stored [NUM_DIRS];
    logic [XW-1:0] gated  [NUM_DIRS];
    logic          drv    [NUM_DIRS];

    // Gather each direction's inputs into arrays indexed by direction.
    assign src[DIR_AB] = a_in;
    assign src[DIR_BA] = b_in;
    assign opn[DIR_AB] = ab_open;
    assign opn[DIR_BA] = ba_open;
    assign stb[DIR_AB] = ab_strobe;
    assign stb[DIR_BA] = ba_strobe;
    assign enp[DIR_AB] = ab_en;
    assign enp[DIR_BA] = ba_en_n;

    // One storage stage and one drive gate per direction.
    generate
        for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
            xcvr_path_store #(
                .W (XW)
            ) u_store (
                .clk    (clk),
                .rst_n  (rst_n),
                .open_i (opn[d]),
                .strobe (stb[d]),
                .din    (src[d]),
                .dout   (stored[d])
            );

            xcvr_drive_gate #(
                .W          (XW),
                .ACTIVE_LOW (dir_enable_low(d))
            ) u_gate (
                .en_pin (enp[d]),
                .din    (stored[d]),
                .drive  (drv[d]),
                .dout   (gated[d])
            );
        end
    endgenerate

    // A-to-B stage drives side B, B-to-A stage drives side A.
    assign b_data  = gated[DIR_AB];
    assign b_drive = drv[DIR_AB];
    assign a_data  = gated[DIR_BA];
    assign a_drive = drv[DIR_BA];

endmodule

// File: rtl/dual_path_xcvr_checks.sv
`timescale 1ns/1ps
// Module: dual_path_xcvr_checks
// Port-level properties of the transceiver, bound to every instance.
// Keeps its own history of the strobes to know when a capture edge happened.
module dual_path_xcvr_checks #(
    parameter int XW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [XW-1:0] a_in,
    input logic [XW-1:0] b_in,
    input logic          ab_open,
    input logic          ba_open,
    input logic          ab_strobe,
    input logic          ba_strobe,
    input logic          ab_en,
    input logic          ba_en_n,
    input logic [XW-1:0] b_data,
    input logic          b_drive,
    input logic [XW-1:0] a_data,
    input logic          a_drive
);

    logic ab_seen;
    logic ba_seen;
    logic ab_edge;
    logic ba_edge;

    // Strobe history as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_seen <= 1'b1;
            ba_seen <= 1'b1;
        end else begin
            ab_seen <= ab_strobe;
            ba_seen <= ba_strobe;
        end
    end

    assign ab_edge = ab_strobe & ~ab_seen;
    assign ba_edge = ba_strobe & ~ba_seen;

    p_open_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_open && ab_en) |-> (b_data == a_in));

    p_close_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_open && $past(ab_open) && $past(rst_n) && ab_en && $past(ab_en))
        |-> (b_data == $past(a_in)));

    p_hold_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_open && !ab_edge && ab_en)
        |=> (ab_open || !ab_en || (b_data == $past(b_data))));

    p_capture_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_open && ab_edge)
        |=> (ab_open || !ab_en || (b_data == $past(a_in))));

    p_b_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en |-> (!b_drive && (b_data == '0)));

    p_a_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ba_en_n |-> (!a_drive && (a_data == '0)));

    p_ba_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_open && ba_edge)
        |=> (ba_open || ba_en_n || (a_data == $past(b_in))));

    p_ba_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_open && !ba_en_n) |-> (a_data == b_in));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !ab_open && ab_en) |-> (b_data == '0));

endmodule

bind dual_path_xcvr dual_path_xcvr_checks #(.XW(XW)) u_checks (.*);

// File: tb/test_dual_path_xcvr.sv
`timescale 1ns/1ps
// Directed bench for dual_path_xcvr: one task per scenario.
module test_dual_path_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         ab_open, ba_open, ab_strobe, ba_strobe, ab_en, ba_en_n;
    logic [W-1:0] b_data, a_data;
    logic         b_drive, a_drive;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    dual_path_xcvr #(.XW(W)) i_dual_path_xcvr (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .ab_open   (ab_open),
        .ba_open   (ba_open),
        .ab_strobe (ab_strobe),
        .ba_strobe (ba_strobe),
        .ab_en     (ab_en),
        .ba_en_n   (ba_en_n),
        .b_data    (b_data),
        .b_drive   (b_drive),
        .a_data    (a_data),
        .a_drive   (a_drive)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0; a_in = '0; b_in = '0;
        ab_open = 0; ba_open = 0; ab_strobe = 0; ba_strobe = 0;
        ab_en = 1; ba_en_n = 0;
        tick(); tick(); #1;
        chk("R9 b_data after reset", b_data, '0);
        chk("R9 a_data after reset", a_data, '0);
        chk("R6 b_drive with ab_en=1", W'(b_drive), W'(1));
        chk("R7 a_drive with ba_en_n=0", W'(a_drive), W'(1));
        rst_n = 1;
        tick();
    endtask

    task automatic t_open_ab();
        ab_open = 1; a_in = 18'h2A5C3; #1;
        chk("R2 open follows", b_data, 18'h2A5C3);
        a_in = 18'h3FFFF; #1;
        chk("R1 all ones", b_data, 18'h3FFFF);
        a_in = 18'h00001; #1;
        chk("R1 bit zero", b_data, 18'h00001);
        chk("R8 a side untouched", a_data, '0);
    endtask

    task automatic t_close_ab();
        a_in = 18'h1234F; tick();
        ab_open = 0; a_in = 18'h0F0F0; #1;
        chk("R3 close keeps last", b_data, 18'h1234F);
        tick();
        chk("R4 hold", b_data, 18'h1234F);
        tick();
        chk("R4 hold again", b_data, 18'h1234F);
    endtask

    task automatic t_capture_ab();
        a_in = 18'h3C3C3; ab_strobe = 1; #1;
        chk("R5 no load before edge", b_data, 18'h1234F);
        tick();
        chk("R5 rising loads", b_data, 18'h3C3C3);
        a_in = 18'h11111; tick();
        chk("R4 high level no load", b_data, 18'h3C3C3);
        ab_strobe = 0; tick();
        chk("R5 falling no load", b_data, 18'h3C3C3);
    endtask

    task automatic t_enable_ab();
        ab_en = 0; #1;
        chk("R6 drive off", W'(b_drive), '0);
        chk("R6 data zero", b_data, '0);
        a_in = 18'h2BEEF; ab_strobe = 1; tick();
        ab_strobe = 0; ab_en = 1; #1;
        chk("R6 stored while off", b_data, 18'h2BEEF);
    endtask

    task automatic t_ba();
        b_in = 18'h0ABCD; ba_open = 1; #1;
        chk("R7 open follows", a_data, 18'h0ABCD);
        chk("R8 b side untouched", b_data, 18'h2BEEF);
        tick();
        ba_open = 0; b_in = 18'h35555; #1;
        chk("R7 close keeps last", a_data, 18'h0ABCD);
        ba_strobe = 1; tick();
        ba_strobe = 0; #1;
        chk("R7 capture", a_data, 18'h35555);
        ba_en_n = 1; #1;
        chk("R7 drive off", W'(a_drive), '0);
        chk("R7 data zero", a_data, '0);
        chk("R8 b drive kept", W'(b_drive), W'(1));
        ba_en_n = 0; tick();
    endtask

    task automatic t_indep();
        a_in = 18'h00F00; ab_strobe = 1; tick();
        ab_strobe = 0; ab_open = 1; #1;
        chk("R8 a side kept", a_data, 18'h35555);
        chk("R5 ab loaded", b_data, 18'h00F00);
        ab_open = 0; tick();
        chk("R8 a side still kept", a_data, 18'h35555);
    endtask

    task automatic t_both();
        a_in = 18'h24924; b_in = 18'h1B6DB;
        ab_strobe = 1; ba_strobe = 1; tick();
        ab_strobe = 0; ba_strobe = 0; #1;
        chk("R10 capture b side", b_data, 18'h24924);
        chk("R10 capture a side", a_data, 18'h1B6DB);
        ab_open = 1; ba_open = 1; a_in = 18'h3FFFF; b_in = '0; #1;
        chk("R10 open b side", b_data, 18'h3FFFF);
        chk("R10 open a side", a_data, '0);
        tick();
        ab_open = 0; ba_open = 0; tick();
    endtask

    task automatic t_reset_strobe();
        ab_strobe = 1; rst_n = 0; tick();
        rst_n = 1; a_in = 18'h15555; tick();
        chk("R9 held strobe not edge", b_data, '0);
        ab_strobe = 0; tick();
        ab_strobe = 1; tick();
        chk("R5 edge after reset", b_data, 18'h15555);
        ab_strobe = 0; tick();
    endtask

    initial begin
        t_reset();
        t_open_ab();
        t_close_ab();
        t_capture_ab();
        t_enable_ab();
        t_ba();
        t_indep();
        t_both();
        t_reset_strobe();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule